// File: doc/BRIEF.md
# Scan Trigger Gate for One Command Queue

This block decides, cycle by cycle, whether one command queue may hand commands to a converter. Software picks one of two continuous scan styles through a mode input. In edge style, a chosen transition on an external trigger line arms the queue. In level style, the trigger line acts as a gate: the queue runs while the gate is open and stops when it closes. The trigger line is asynchronous and passes through a synchroniser chain before any decision is made.

The block reports a two-bit queue status (idle, waiting for trigger, triggered) and drives a transfer-enable that the command FIFO and link logic use. A higher-priority queue that becomes triggered masks the enable without disturbing the status. End-of-queue and pause marks carried by sent commands never halt a continuous scan. An end-of-queue command sent while triggered produces a one-cycle strobe. When the gate closes during a serial transmission to an external device, the status change is held back until that transmission ends. No further transfers are enabled in the meantime.

Top module: `sqt_scan_ctrl`

## Requirements
- R1: Status encoding is 2'b00 idle, 2'b10 waiting for trigger and 2'b11 triggered. After reset the status is idle, transfer-enable is low and the strobe is low. The value 2'b01 never appears.
- R2: Mode 2'b00 (disabled) and mode 2'b11 (reserved) force transfer-enable low in the same cycle. The status becomes idle on the next clock edge.
- R3: Selecting a continuous mode (2'b01 edge, 2'b10 level) from idle, or switching between the two continuous modes, sets the status to waiting on the next clock edge. Transfer-enable is low during the cycle of the switch.
- R4: In edge mode the trigger passes through SYNC_STAGES flip-flops before edge detection. trig_cfg selects the edge: bit 0 enables rising edges and bit 1 enables falling edges. A selected edge moves waiting to triggered one clock edge after it leaves the synchroniser. An edge that is not selected has no effect.
- R5: In level mode the gate is open while the synchronised trigger equals trig_cfg[0]. An open gate moves waiting to triggered on the next clock edge.
- R6: In level mode with ser_busy low, a closing gate drops transfer-enable in the cycle the synchronised trigger shows it closed. The status returns to waiting on the next clock edge.
- R7: In level mode, a gate that closes while ser_busy is high keeps the status triggered and transfer-enable low. The status becomes waiting on the first clock edge with ser_busy low.
- R8: While hp_trig is high, transfer-enable is low in the same cycle and a triggered status stays triggered. The enable returns when hp_trig falls.
- R9: cmd_eoq and cmd_pause on a sent command change neither the status nor transfer-enable in either continuous mode.
- R10: last_cmd pulses high for one cycle, one clock edge after a cycle in which cmd_sent and cmd_eoq are both high while the status is triggered. In any other status the pulse does not occur.
- R11: Transfer-enable is high only while the status is triggered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | 00 disabled, 01 continuous edge, 10 continuous level, 11 reserved |
| trig_cfg | input | 2 | Edge mode: bit 0 rising, bit 1 falling; level mode: bit 0 is the gate-open level |
| trig_in | input | 1 | Asynchronous trigger or gate line |
| hp_trig | input | 1 | A higher-priority queue is triggered |
| ser_busy | input | 1 | A serial command transmission is in flight |
| cmd_sent | input | 1 | A command left the queue this cycle |
| cmd_eoq | input | 1 | The sent command carries an end-of-queue mark |
| cmd_pause | input | 1 | The sent command carries a pause mark |
| q_status | output | 2 | Queue status |
| xfer_en | output | 1 | Queue may transfer commands |
| last_cmd | output | 1 | One-cycle strobe after an end-of-queue command |

## Verification
The bench builds the block with SYNC_STAGES set to 3 and DEFER_CLOSE set to 1. A three-deep chain shows that the synchroniser latency follows the parameter rather than a fixed two-cycle value. The bench counts that latency exactly for edge arrival and for gate closure. With deferral enabled, the bench can hold ser_busy across a gate closure and observe the status change when it finally lands.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_WAIT = 2'b10,
      ST_TRIG = 2'b11
   } sqt_stat_e;

   localparam logic [1:0] MD_OFF   = 2'b00;
   localparam logic [1:0] MD_EDGE  = 2'b01;
   localparam logic [1:0] MD_LEVEL = 2'b10;
   localparam logic [1:0] MD_RSVD  = 2'b11;

   function automatic logic is_cont(input logic [1:0] m);
      return (m == MD_EDGE) || (m == MD_LEVEL);
   endfunction

endpackage

// File: rtl/sqt_trig_sync.sv
module sqt_trig_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o,
   output logic prev_o
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain_q;
   logic          prev_q;

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RST_VAL;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RST_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= chain_q[LAST];
   end

   assign sync_o = chain_q[LAST];
   assign prev_o = prev_q;
endmodule

// File: rtl/sqt_trig_eval.sv
module sqt_trig_eval (
   input  logic [1:0] cfg,
   input  logic       sync_lvl,
   input  logic       prev_lvl,
   output logic       edge_hit,
   output logic       gate_open
);
   logic rise, fall;

   always_comb begin
      rise      = sync_lvl & ~prev_lvl;
      fall      = ~sync_lvl & prev_lvl;
      edge_hit  = (cfg[0] & rise) | (cfg[1] & fall);
      gate_open = (sync_lvl == cfg[0]);
   end
endmodule

// File: rtl/sqt_status_fsm.sv
module sqt_status_fsm
   import sqt_pkg::*;
#(
   parameter bit DEFER_CLOSE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       edge_hit,
   input  logic       gate_open,
   input  logic       ser_busy,
   input  logic       hp_trig,
   input  logic       cmd_sent,
   input  logic       cmd_eoq,
   output sqt_stat_e  status,
   output logic       xfer_en,
   output logic       last_cmd
);
   sqt_stat_e  st_q, st_d;
   logic [1:0] mode_q;
   logic       last_q;
   logic       pend_q;
   logic       cont, mode_chg, gate_shut, hold, close_req;

   always_comb begin
      cont      = is_cont(mode);
      mode_chg  = (mode != mode_q);
      gate_shut = (mode == MD_LEVEL) && !gate_open;
   end

   generate
      if (DEFER_CLOSE) begin : g_defer
         logic pend_d;
         always_comb begin
            pend_d = pend_q;
            if (!cont || mode_chg || st_q != ST_TRIG) pend_d = 1'b0;
            else if (gate_shut && ser_busy)          pend_d = 1'b1;
            else if (!ser_busy)                      pend_d = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= pend_d;
         end
         assign hold = ser_busy;
      end else begin : g_direct
         assign pend_q = 1'b0;
         assign hold   = 1'b0;
      end
   endgenerate

   assign close_req = gate_shut || pend_q;

   always_comb begin
      st_d = st_q;
      if (!cont) begin
         st_d = ST_IDLE;
      end else if (mode_chg || st_q == ST_IDLE) begin
         st_d = ST_WAIT;
      end else begin
         unique case (st_q)
            ST_WAIT: begin
               if ((mode == MD_EDGE && edge_hit) || (mode == MD_LEVEL && gate_open))
                  st_d = ST_TRIG;
            end
            ST_TRIG: begin
               if (close_req && !hold) st_d = ST_WAIT;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= MD_OFF;
         last_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode;
         last_q <= cmd_sent && cmd_eoq && (st_q == ST_TRIG) && cont;
      end
   end

   assign xfer_en  = cont && !mode_chg && (st_q == ST_TRIG) && !hp_trig
                     && !gate_shut && !pend_q;
   assign status   = st_q;
   assign last_cmd = last_q;
endmodule

// File: rtl/sqt_scan_ctrl.sv
module sqt_scan_ctrl
   import sqt_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter bit   DEFER_CLOSE = 1'b1,
   parameter logic TRIG_RST    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic [1:0] trig_cfg,
   input  logic       trig_in,
   input  logic       hp_trig,
   input  logic       ser_busy,
   input  logic       cmd_sent,
   input  logic       cmd_eoq,
   input  logic       cmd_pause,
   output logic [1:0] q_status,
   output logic       xfer_en,
   output logic       last_cmd
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sqt_scan_ctrl: SYNC_STAGES must be at least 2");
      end
      if (SYNC_STAGES > 8) begin : g_big_sync
         $error("sqt_scan_ctrl: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   logic      sync_lvl, prev_lvl, edge_hit, gate_open;
   sqt_stat_e status;

   sqt_trig_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (TRIG_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (trig_in),
      .sync_o  (sync_lvl),
      .prev_o  (prev_lvl)
   );

   sqt_trig_eval u_eval (
      .cfg       (trig_cfg),
      .sync_lvl  (sync_lvl),
      .prev_lvl  (prev_lvl),
      .edge_hit  (edge_hit),
      .gate_open (gate_open)
   );

   sqt_status_fsm #(
      .DEFER_CLOSE (DEFER_CLOSE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_sel),
      .edge_hit  (edge_hit),
      .gate_open (gate_open),
      .ser_busy  (ser_busy),
      .hp_trig   (hp_trig),
      .cmd_sent  (cmd_sent),
      .cmd_eoq   (cmd_eoq),
      .status    (status),
      .xfer_en   (xfer_en),
      .last_cmd  (last_cmd)
   );

   assign q_status = status;
endmodule

// File: rtl/sqt_scan_ctrl_chk.sv
module sqt_scan_ctrl_chk #(
   parameter bit DEFER_CLOSE = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic       hp_trig,
   input logic       ser_busy,
   input logic       cmd_sent,
   input logic       cmd_eoq,
   input logic       cmd_pause,
   input logic [1:0] q_status,
   input logic       xfer_en,
   input logic       last_cmd
);
   logic off_mode;
   assign off_mode = (mode_sel == 2'b00) || (mode_sel == 2'b11);

   AST_LEGAL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      q_status != 2'b01);  // R1

   AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      off_mode |=> (q_status == 2'b00));  // R2

   AST_OFF_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      off_mode |-> !xfer_en);  // R2

   AST_IDLE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (q_status == 2'b00 && !off_mode) |=> (q_status == 2'b10));  // R3

   AST_HP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      hp_trig |-> !xfer_en);  // R8

   AST_HP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (q_status == 2'b11 && hp_trig && mode_sel == 2'b01 && $past(mode_sel) == 2'b01)
      |=> (q_status == 2'b11));  // R8

   AST_FLAG_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (q_status == 2'b11 && cmd_sent && (cmd_eoq || cmd_pause)
       && mode_sel == 2'b01 && $past(mode_sel) == 2'b01)
      |=> (q_status == 2'b11));  // R9

   AST_BUSY_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      (DEFER_CLOSE && q_status == 2'b11 && ser_busy
       && mode_sel == 2'b10 && $past(mode_sel) == 2'b10)
      |=> (q_status == 2'b11));  // R7

   AST_LAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      last_cmd |-> $past(cmd_sent && cmd_eoq));  // R10

   AST_XFER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_en |-> (q_status == 2'b11));  // R11
endmodule

bind sqt_scan_ctrl sqt_scan_ctrl_chk #(
   .DEFER_CLOSE (DEFER_CLOSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .hp_trig   (hp_trig),
   .ser_busy  (ser_busy),
   .cmd_sent  (cmd_sent),
   .cmd_eoq   (cmd_eoq),
   .cmd_pause (cmd_pause),
   .q_status  (q_status),
   .xfer_en   (xfer_en),
   .last_cmd  (last_cmd)
);

// File: tb/sim_sqt_scan_ctrl.sv
`timescale 1ns/1ps
module sim_sqt_scan_ctrl;
   localparam int NS = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [1:0] trig_cfg = 2'b01;
   logic       trig_in = 1'b0;
   logic       hp_trig = 1'b0;
   logic       ser_busy = 1'b0;
   logic       cmd_sent = 1'b0;
   logic       cmd_eoq = 1'b0;
   logic       cmd_pause = 1'b0;
   logic [1:0] q_status;
   logic       xfer_en;
   logic       last_cmd;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sqt_scan_ctrl #(
      .SYNC_STAGES (NS),
      .DEFER_CLOSE (1'b1)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .trig_cfg  (trig_cfg),
      .trig_in   (trig_in),
      .hp_trig   (hp_trig),
      .ser_busy  (ser_busy),
      .cmd_sent  (cmd_sent),
      .cmd_eoq   (cmd_eoq),
      .cmd_pause (cmd_pause),
      .q_status  (q_status),
      .xfer_en   (xfer_en),
      .last_cmd  (last_cmd)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset();
      check("R1 status", q_status, 2'b00);
      check("R1 xfer", {1'b0, xfer_en}, 2'b00);
      check("R1 last", {1'b0, last_cmd}, 2'b00);
   endtask

   task automatic t_edge_rise();
      mode_sel = 2'b01; trig_cfg = 2'b01;
      #1 check("R3 switch-cycle xfer", {1'b0, xfer_en}, 2'b00);
      tick(1);
      check("R3 wait", q_status, 2'b10);
      check("R11 no xfer in wait", {1'b0, xfer_en}, 2'b00);
      trig_in = 1'b1;
      tick(NS);
      check("R4 still waiting inside sync", q_status, 2'b10);
      tick(1);
      check("R4 rising trig", q_status, 2'b11);
      check("R11 xfer", {1'b0, xfer_en}, 2'b01);
   endtask

   task automatic t_flags();
      cmd_sent = 1'b1; cmd_eoq = 1'b1; cmd_pause = 1'b1;
      tick(1);
      cmd_sent = 1'b0; cmd_eoq = 1'b0; cmd_pause = 1'b0;
      check("R9 status kept", q_status, 2'b11);
      check("R9 xfer kept", {1'b0, xfer_en}, 2'b01);
      check("R10 strobe", {1'b0, last_cmd}, 2'b01);
      tick(1);
      check("R10 strobe one cycle", {1'b0, last_cmd}, 2'b00);
      cmd_sent = 1'b1; cmd_pause = 1'b1;
      tick(1);
      cmd_sent = 1'b0; cmd_pause = 1'b0;
      check("R9 pause only", q_status, 2'b11);
      check("R10 no strobe w/o eoq", {1'b0, last_cmd}, 2'b00);
   endtask

   task automatic t_hp();
      hp_trig = 1'b1;
      #1 check("R8 xfer masked", {1'b0, xfer_en}, 2'b00);
      tick(2);
      check("R8 status kept", q_status, 2'b11);
      hp_trig = 1'b0;
      #1 check("R8 resume", {1'b0, xfer_en}, 2'b01);
   endtask

   task automatic t_disable();
      mode_sel = 2'b00;
      #1 check("R2 xfer off", {1'b0, xfer_en}, 2'b00);
      tick(1);
      check("R2 idle", q_status, 2'b00);
   endtask

   task automatic t_edge_fall();
      trig_in = 1'b0;
      tick(NS + 2);
      mode_sel = 2'b01; trig_cfg = 2'b10;
      tick(1);
      check("R3 wait again", q_status, 2'b10);
      trig_in = 1'b1;
      tick(NS + 2);
      check("R4 rising ignored", q_status, 2'b10);
      trig_in = 1'b0;
      tick(NS + 1);
      check("R4 falling trig", q_status, 2'b11);
   endtask

   task automatic t_level();
      mode_sel = 2'b10; trig_cfg = 2'b01;
      #1 check("R3 mode switch xfer", {1'b0, xfer_en}, 2'b00);
      tick(1);
      check("R3 switch to wait", q_status, 2'b10);
      tick(3);
      check("R5 closed gate waits", q_status, 2'b10);
      trig_in = 1'b1;
      tick(NS + 1);
      check("R5 gate open trig", q_status, 2'b11);
      check("R11 level xfer", {1'b0, xfer_en}, 2'b01);
   endtask

   task automatic t_close_idle();
      trig_in = 1'b0;
      tick(NS);
      check("R6 xfer drops", {1'b0, xfer_en}, 2'b00);
      check("R6 status not yet", q_status, 2'b11);
      tick(1);
      check("R6 back to wait", q_status, 2'b10);
   endtask

   task automatic t_close_busy();
      trig_in = 1'b1;
      tick(NS + 1);
      check("R5 reopen", q_status, 2'b11);
      ser_busy = 1'b1;
      trig_in = 1'b0;
      tick(NS);
      check("R7 xfer stops", {1'b0, xfer_en}, 2'b00);
      tick(1);
      check("R7 status held", q_status, 2'b11);
      tick(3);
      check("R7 still held", q_status, 2'b11);
      check("R7 xfer still off", {1'b0, xfer_en}, 2'b00);
      ser_busy = 1'b0;
      tick(1);
      check("R7 applied after busy", q_status, 2'b10);
   endtask

   task automatic t_low_gate();
      trig_cfg = 2'b00;
      tick(1);
      check("R5 open-low gate", q_status, 2'b11);
   endtask

   task automatic t_reserved();
      mode_sel = 2'b11;
      #1 check("R2 reserved xfer", {1'b0, xfer_en}, 2'b00);
      tick(1);
      check("R2 reserved idle", q_status, 2'b00);
   endtask

   task automatic t_strobe_wait();
      mode_sel = 2'b10; trig_cfg = 2'b01;
      tick(1);
      check("R3 wait for strobe test", q_status, 2'b10);
      cmd_sent = 1'b1; cmd_eoq = 1'b1;
      tick(1);
      cmd_sent = 1'b0; cmd_eoq = 1'b0;
      check("R10 no strobe in wait", {1'b0, last_cmd}, 2'b00);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_edge_rise();
      t_flags();
      t_hp();
      t_disable();
      t_edge_fall();
      t_level();
      t_close_idle();
      t_close_busy();
      t_low_gate();
      t_reserved();
      t_strobe_wait();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule